// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the per-cycle address for a synchronous memory that accepts a start address and then runs a burst of four beats on its own. On a load cycle it captures an external address and opens a new read, a new write or a deselect, depending on the chip select and the write strobe. On each continue cycle it steps the two least significant address bits. The upper bits stay frozen for the whole burst. The low bits count upward modulo four when the order strap is low. When the strap is high they are the captured low bits XORed with the beat number.

A small state machine records what kind of burst is in flight, so that a continue cycle takes on the read, write or idle type of the burst it extends. A stall input freezes the whole block for as many cycles as it is held. Both outputs come from registers, so a command sampled at one rising edge is visible after that edge.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, burst_state is 0 (idle) and eff_addr is 0.
- R2: A load cycle (stall low, advance low, chip_sel high) makes eff_addr equal ext_addr after the edge. burst_state becomes 1 (new read) when wr_n is high and 2 (new write) when wr_n is low.
- R3: A load cycle with chip_sel low sets burst_state to 0 (idle) and leaves eff_addr unchanged.
- R4: With ilv_order low, continue cycles (stall low, advance high) give low bits of start+1, start+2 and start+3, all modulo 4.
- R5: With ilv_order high, continue cycles give low bits of start XOR 1, start XOR 2 and start XOR 3.
- R6: The fourth continue cycle returns the low bits to the loaded start value, and later continue cycles repeat the same order.
- R7: A continue cycle moves state 1 to 3 (read burst) and state 2 to 4 (write burst), and it keeps states 3 and 4 unchanged. The values of wr_n and chip_sel on a continue cycle have no effect.
- R8: A continue cycle in state 0 leaves burst_state at 0 and eff_addr unchanged.
- R9: While stall is high, burst_state and eff_addr hold their values. The next continue cycle then gives the beat that follows the one before the stall.
- R10: During a burst, the address bits above the low two keep the values captured at load time, whatever ext_addr does on continue cycles.
- R11: A load cycle issued in the middle of a burst restarts the sequence from the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | High freezes the state and the address |
| advance | input | 1 | Low = load external address, high = continue burst |
| wr_n | input | 1 | Write strobe for a load cycle, active low |
| chip_sel | input | 1 | Combined select, high = selected |
| ilv_order | input | 1 | Order strap: 0 = linear, 1 = interleaved |
| ext_addr | input | ADDR_W | External start address |
| eff_addr | output | ADDR_W | Registered effective address |
| burst_state | output | 3 | 0 idle, 1 new read, 2 new write, 3 read burst, 4 write burst |

## Verification
Two functions can land in the same cycle: a stall and a pending continue command. The bench holds stall high while advance stays high in the middle of a burst. It expects eff_addr and burst_state to stay frozen. It then expects the next unstalled continue to give exactly the following beat, with no beat skipped or repeated. A second overlap comes from a load issued in the middle of a burst. The bench expects the new start address to win over the next beat of the old burst, and the next continue to step from the new start.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_NEW   = 3'd1,
    ST_WR_NEW   = 3'd2,
    ST_RD_BURST = 3'd3,
    ST_WR_BURST = 3'd4
  } burst_state_e;

  typedef struct packed {
    logic load;     // enabled load with select
    logic load_wr;  // the load is a write
    logic desel;    // enabled load without select
    logic cont;     // enabled continue
  } burst_cmd_t;

endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
  import burst_pkg::*;
(
  input  logic       stall,
  input  logic       advance,
  input  logic       wr_n,
  input  logic       chip_sel,
  output burst_cmd_t cmd
);

  logic active;

  always_comb begin
    active       = !stall;
    cmd.load     = active && !advance && chip_sel;
    cmd.load_wr  = active && !advance && chip_sel && !wr_n;
    cmd.desel    = active && !advance && !chip_sel;
    cmd.cont     = active && advance;
  end

endmodule

// File: rtl/burst_state_fsm.sv
module burst_state_fsm
  import burst_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  burst_cmd_t   cmd,
  output burst_state_e state_q,
  output logic         step
);

  burst_state_e state_d;

  // a continue only advances the counter when a burst is open
  assign step = cmd.cont && (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    if (cmd.load) begin
      state_d = cmd.load_wr ? ST_WR_NEW : ST_RD_NEW;
    end else if (cmd.desel) begin
      state_d = ST_IDLE;
    end else if (cmd.cont) begin
      case (state_q)
        ST_RD_NEW:   state_d = ST_RD_BURST;
        ST_WR_NEW:   state_d = ST_WR_BURST;
        ST_RD_BURST: state_d = ST_RD_BURST;
        ST_WR_BURST: state_d = ST_WR_BURST;
        default:     state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  p_rd_inherit_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd.cont && (state_q == ST_RD_NEW || state_q == ST_RD_BURST)) |=> state_q == ST_RD_BURST);

  p_wr_inherit_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd.cont && (state_q == ST_WR_NEW || state_q == ST_WR_BURST)) |=> state_q == ST_WR_BURST);

  p_legal_code_r1: assert property (@(posedge clk) disable iff (rst)
    state_q inside {ST_IDLE, ST_RD_NEW, ST_WR_NEW, ST_RD_BURST, ST_WR_BURST});

endmodule

// File: rtl/burst_addr_counter.sv
module burst_addr_counter #(
  parameter int ADDR_W     = 8,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic              ilv_order,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] eff_addr
);

  localparam int HI_W = ADDR_W - BURST_BITS;

  logic [BURST_BITS-1:0] base_lo;
  logic [BURST_BITS-1:0] beat_q;
  logic [BURST_BITS-1:0] beat_nx;
  logic [BURST_BITS-1:0] lo_q;
  logic [BURST_BITS-1:0] lo_nx;
  logic [HI_W-1:0]       hi_q;

  always_comb begin
    beat_nx = beat_q + BURST_BITS'(1);
    lo_nx   = ilv_order ? (base_lo ^ beat_nx) : (base_lo + beat_nx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_lo <= '0;
      beat_q  <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else if (load) begin
      base_lo <= ext_addr[BURST_BITS-1:0];
      beat_q  <= '0;
      lo_q    <= ext_addr[BURST_BITS-1:0];
      hi_q    <= ext_addr[ADDR_W-1:BURST_BITS];
    end else if (step) begin
      beat_q  <= beat_nx;
      lo_q    <= lo_nx;
    end
  end

  assign eff_addr = {hi_q, lo_q};

  p_linear_step_r4: assert property (@(posedge clk) disable iff (rst)
    (step && !load && !ilv_order) |=> eff_addr[BURST_BITS-1:0] == $past(eff_addr[BURST_BITS-1:0]) + BURST_BITS'(1));

  p_upper_fixed_r10: assert property (@(posedge clk) disable iff (rst)
    (!load) |=> $stable(eff_addr[ADDR_W-1:BURST_BITS]));

  p_load_addr_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> eff_addr == $past(ext_addr));

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic              advance,
  input  logic              wr_n,
  input  logic              chip_sel,
  input  logic              ilv_order,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [2:0]        burst_state
);

  burst_cmd_t   cmd;
  burst_state_e st;
  logic         step;

  burst_cmd_decode i_decode (
    .stall    (stall),
    .advance  (advance),
    .wr_n     (wr_n),
    .chip_sel (chip_sel),
    .cmd      (cmd)
  );

  burst_state_fsm i_fsm (
    .clk     (clk),
    .rst     (rst),
    .cmd     (cmd),
    .state_q (st),
    .step    (step)
  );

  burst_addr_counter #(
    .ADDR_W     (ADDR_W),
    .BURST_BITS (BURST_BITS)
  ) i_counter (
    .clk       (clk),
    .rst       (rst),
    .load      (cmd.load),
    .step      (step),
    .ilv_order (ilv_order),
    .ext_addr  (ext_addr),
    .eff_addr  (eff_addr)
  );

  assign burst_state = st;

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(burst_state) && $stable(eff_addr)));

  p_idle_cont_r8: assert property (@(posedge clk) disable iff (rst)
    (!stall && advance && burst_state == 3'd0) |=> (burst_state == 3'd0 && $stable(eff_addr)));

  p_desel_load_r3: assert property (@(posedge clk) disable iff (rst)
    (!stall && !advance && !chip_sel) |=> (burst_state == 3'd0 && $stable(eff_addr)));

  p_load_type_r2: assert property (@(posedge clk) disable iff (rst)
    (!stall && !advance && chip_sel) |=> burst_state == ($past(wr_n) ? 3'd1 : 3'd2));

endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          stall = 1'b1;
  logic          advance = 1'b0;
  logic          wr_n = 1'b1;
  logic          chip_sel = 1'b0;
  logic          ilv_order = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] eff_addr;
  logic [2:0]    burst_state;

  int  total = 0;
  int  bad = 0;
  bit  finished = 1'b0;

  logic [2:0]    m_st = 3'd0;
  logic [1:0]    m_base = 2'd0;
  logic [1:0]    m_cnt = 2'd0;
  logic [AW-1:0] m_addr = '0;

  logic [2:0]    q_st[$];
  logic [AW-1:0] q_ad[$];
  string         q_tag[$];

  logic [2:0]    e_st;
  logic [AW-1:0] e_ad;
  string         e_tag;

  burst_addr_gen #(.ADDR_W(AW), .BURST_BITS(2)) i_burst_addr_gen (
    .clk(clk), .rst(rst), .stall(stall), .advance(advance), .wr_n(wr_n),
    .chip_sel(chip_sel), .ilv_order(ilv_order), .ext_addr(ext_addr),
    .eff_addr(eff_addr), .burst_state(burst_state)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [2:0] st_exp, input logic [AW-1:0] ad_exp);
    total++;
    if (burst_state !== st_exp || eff_addr !== ad_exp) begin
      bad++;
      $display("FAIL %s: actual state=%0d addr=%h expected state=%0d addr=%h",
               tag, burst_state, eff_addr, st_exp, ad_exp);
    end
  endtask

  // driver: apply one command, update the reference model, queue the expectation
  task automatic cyc(input logic s, input logic a, input logic w, input logic cs,
                     input logic [AW-1:0] ad, input string tag);
    @(negedge clk);
    stall = s; advance = a; wr_n = w; chip_sel = cs; ext_addr = ad;
    if (!s) begin
      if (!a) begin
        if (cs) begin
          m_st = w ? 3'd1 : 3'd2;
          m_base = ad[1:0];
          m_cnt = 2'd0;
          m_addr = ad;
        end else begin
          m_st = 3'd0;
        end
      end else if (m_st != 3'd0) begin
        m_cnt = m_cnt + 2'd1;
        m_addr[1:0] = ilv_order ? (m_base ^ m_cnt) : (m_base + m_cnt);
        if (m_st == 3'd1) m_st = 3'd3;
        else if (m_st == 3'd2) m_st = 3'd4;
      end
    end
    @(posedge clk);
    #1;
    q_st.push_back(m_st);
    q_ad.push_back(m_addr);
    q_tag.push_back(tag);
  endtask

  // monitor: compare design outputs with queued expectations
  always @(posedge clk) begin
    #2;
    while (q_st.size() > 0) begin
      e_st = q_st.pop_front();
      e_ad = q_ad.pop_front();
      e_tag = q_tag.pop_front();
      check(e_tag, e_st, e_ad);
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in reset", 3'd0, '0);
    rst = 1'b0;
    @(posedge clk);
    #3;
    check("R1 after reset", 3'd0, '0);

    // linear read burst from 0x35, junk on wr_n/chip_sel/ext_addr while continuing
    ilv_order = 1'b0;
    cyc(0, 0, 1, 1, 8'h35, "R2 load read");
    cyc(0, 1, 0, 0, 8'hFF, "R4 R7 R10 linear beat1");
    cyc(0, 1, 1, 0, 8'h00, "R4 R10 linear beat2");
    cyc(0, 1, 0, 1, 8'hC3, "R4 linear beat3");
    cyc(0, 1, 1, 1, 8'h7E, "R6 linear wrap");
    cyc(0, 1, 0, 0, 8'h11, "R6 linear repeat");
    // stall overlapping a continue
    cyc(1, 1, 0, 1, 8'hAA, "R9 stall hold");
    cyc(1, 0, 0, 1, 8'h55, "R9 stall over load");
    cyc(0, 1, 1, 1, 8'h99, "R9 resume next beat");

    // interleaved write burst from 0xA2
    cyc(0, 0, 1, 0, 8'h00, "R3 deselect before strap");
    ilv_order = 1'b1;
    cyc(0, 0, 0, 1, 8'hA2, "R2 load write");
    cyc(0, 1, 1, 0, 8'h0F, "R5 R7 interleaved beat1");
    cyc(0, 1, 1, 1, 8'hF0, "R5 R7 interleaved beat2");
    cyc(0, 1, 0, 1, 8'h33, "R5 R10 interleaved beat3");
    cyc(0, 1, 0, 0, 8'h44, "R6 interleaved wrap");
    cyc(0, 1, 1, 0, 8'h44, "R6 interleaved repeat");

    // restart mid burst
    cyc(0, 0, 1, 1, 8'h4C, "R11 load mid burst");
    cyc(0, 1, 0, 0, 8'h00, "R11 R5 step from new start");

    // deselect and idle continue
    cyc(0, 0, 0, 0, 8'hE7, "R3 deselect load");
    cyc(0, 1, 1, 1, 8'h12, "R8 continue while idle");
    cyc(0, 1, 0, 1, 8'h34, "R8 second idle continue");
    cyc(1, 1, 0, 1, 8'h34, "R9 stall while idle");

    // linear write with wrap inside one step
    ilv_order = 1'b0;
    cyc(0, 0, 0, 1, 8'h13, "R2 load write linear");
    cyc(0, 1, 1, 1, 8'hFF, "R4 R7 wrap low bits");
    cyc(0, 1, 1, 1, 8'hFF, "R4 write burst stays");

    repeat (3) @(posedge clk);
    #4;
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule